// File: doc/BRIEF.md
# Split-Phase Handshake Protocol Monitor

This block watches one initiator port of a request/response channel. On that port every transaction passes through four separate phase events: request-begin, request-end, response-begin and response-end. Each event arrives as a one-cycle strobe that carries a transaction ID. The monitor is passive. It carries no payload and never drives the channel. It keeps the phase of every live ID in a small table, one entry per ID value, and raises an error pulse with a 3-bit code whenever the traffic breaks the handshake rules.

The rules cover backpressure in both directions. A target that delays request-end holds the initiator out of every new request. An initiator that delays response-end holds the target out of every new response. The rules also cover the allowed shortcuts: a target may answer without a request-end, either end phase may be waived by a same-cycle acknowledgment flag, and the whole transaction may be finished at request-begin. Several transactions may be open at once, and responses may come back in any order.

All events in one clock cycle are judged against the table state from before that cycle. An event that breaks a rule leaves the table untouched, and the monitor carries on with the events that follow.

Top module: `split_phase_monitor`

## Requirements
- R1: A normal transaction passes request-begin, request-end, response-begin and response-end for its ID. None of these phases raises an error. After response-end the ID is free again, so a further response-begin for it is reported as code 4.
- R2: While any ID waits for its request-end, a request-begin for any ID is reported as code 1. The wait ends in the cycle after request-end arrives.
- R3: While any ID waits for its response-end, a response-begin for any ID is reported as code 3. That response-begin is ignored.
- R4: A response-begin for an ID that still waits for its request-end is accepted. It stands in for the request-end and releases the request exclusion. A later request-end for that ID is reported as code 5.
- R5: If `req_bgn_upd` is high with request-begin, no request-end is expected and no exclusion starts. If `rsp_bgn_upd` is high with response-begin, no response-end is expected and the ID is freed. A response-end sent afterwards is reported as code 6.
- R6: If `req_bgn_fin` is high with request-begin, the transaction completes at once. A later response-begin for that ID is code 4, a later request-end for it is code 5, and the ID may be requested again.
- R7: Several IDs may be open at once. They may finish in any order without error.
- R8: A request-begin for an ID that is still live is code 2. A response-begin for an ID with no accepted request is code 4.
- R9: A request-end for an ID that is not waiting for one is code 5. A response-end for an ID that is not waiting for one is code 6.
- R10: Each offending cycle produces `err_vld` high for exactly one cycle, in the cycle after the event, together with its code. If one cycle has several errors, the lowest code is reported. Rejected events change no state, and checking goes on.
- R11: A synchronous active-high `rst` clears every ID to idle and clears the error output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_bgn_vld | input | 1 | Request-begin event |
| req_bgn_id | input | ID_W | ID of request-begin |
| req_bgn_upd | input | 1 | Target waives request-end |
| req_bgn_fin | input | 1 | Transaction completed at request-begin |
| req_end_vld | input | 1 | Request-end event |
| req_end_id | input | ID_W | ID of request-end |
| rsp_bgn_vld | input | 1 | Response-begin event |
| rsp_bgn_id | input | ID_W | ID of response-begin |
| rsp_bgn_upd | input | 1 | Initiator waives response-end |
| rsp_end_vld | input | 1 | Response-end event |
| rsp_end_id | input | ID_W | ID of response-end |
| err_vld | output | 1 | One-cycle error pulse |
| err_code | output | 3 | Error code: 0 means none |

## Verification
Some properties are checked on every cycle:
- At most one ID waits for request-end, and at most one waits for response-end.
- A request-begin inside the exclusion window always yields code 1 one cycle later.
- A stray request-end always raises the error pulse.
- An early-completed request leaves its ID idle.

Other behaviour only the directed scenarios can show. These include the exact codes for orphan responses, reused IDs and stray ends; the release of the exclusion by an implicit request-end; the waived end phases; out-of-order completion; the lowest-code-wins rule; and a reset that lands in the middle of a transaction.

// File: rtl/sph_pkg.sv
package sph_pkg;
  typedef enum logic [1:0] {
    ST_IDLE     = 2'd0,
    ST_REQ_OPEN = 2'd1,
    ST_RSP_WAIT = 2'd2,
    ST_RSP_OPEN = 2'd3
  } sph_state_e;

  localparam logic [2:0] ERR_NONE     = 3'd0;
  localparam logic [2:0] ERR_EXCL     = 3'd1;
  localparam logic [2:0] ERR_REUSE    = 3'd2;
  localparam logic [2:0] ERR_RSP_BUSY = 3'd3;
  localparam logic [2:0] ERR_ORPHAN   = 3'd4;
  localparam logic [2:0] ERR_REQ_END  = 3'd5;
  localparam logic [2:0] ERR_RSP_END  = 3'd6;
endpackage

// File: rtl/sph_state_table.sv
module sph_state_table
  import sph_pkg::*;
#(
  parameter int ID_W = 3
) (
  input  logic                          clk,
  input  logic                          rst,
  input  sph_state_e [(1<<ID_W)-1:0]    nxt_state,
  output sph_state_e [(1<<ID_W)-1:0]    cur_state,
  output logic       [(1<<ID_W)-1:0]    req_open_vec,
  output logic       [(1<<ID_W)-1:0]    rsp_open_vec
);
  localparam int NUM_IDS = 1 << ID_W;

  for (genvar i = 0; i < NUM_IDS; i++) begin : g_entry
    always_ff @(posedge clk) begin
      if (rst) cur_state[i] <= ST_IDLE;
      else     cur_state[i] <= nxt_state[i];
    end
    assign req_open_vec[i] = (cur_state[i] == ST_REQ_OPEN);
    assign rsp_open_vec[i] = (cur_state[i] == ST_RSP_OPEN);
  end

  // R2: exclusion leaves at most one request waiting for its end
  a_r2_single_req_open: assert property (@(posedge clk) disable iff (rst)
    $countones(req_open_vec) <= 1);

  // R3: response backpressure leaves at most one response waiting for its end
  a_r3_single_rsp_open: assert property (@(posedge clk) disable iff (rst)
    $countones(rsp_open_vec) <= 1);
endmodule

// File: rtl/sph_rules.sv
module sph_rules
  import sph_pkg::*;
#(
  parameter int ID_W = 3
) (
  input  sph_state_e [(1<<ID_W)-1:0] cur_state,
  input  logic                       req_bgn_vld,
  input  logic [ID_W-1:0]            req_bgn_id,
  input  logic                       req_bgn_upd,
  input  logic                       req_bgn_fin,
  input  logic                       req_end_vld,
  input  logic [ID_W-1:0]            req_end_id,
  input  logic                       rsp_bgn_vld,
  input  logic [ID_W-1:0]            rsp_bgn_id,
  input  logic                       rsp_bgn_upd,
  input  logic                       rsp_end_vld,
  input  logic [ID_W-1:0]            rsp_end_id,
  output sph_state_e [(1<<ID_W)-1:0] nxt_state,
  output logic [2:0]                 err_c
);
  localparam int NUM_IDS = 1 << ID_W;

  logic excl_active, rsp_blocked;
  logic bad_excl, bad_reuse, bad_busy, bad_orphan, bad_req_end, bad_rsp_end;

  always_comb begin
    excl_active = 1'b0;
    rsp_blocked = 1'b0;
    for (int i = 0; i < NUM_IDS; i++) begin
      if (cur_state[i] == ST_REQ_OPEN) excl_active = 1'b1;
      if (cur_state[i] == ST_RSP_OPEN) rsp_blocked = 1'b1;
    end
  end

  always_comb begin
    bad_excl    = req_bgn_vld && excl_active;
    bad_reuse   = req_bgn_vld && (cur_state[req_bgn_id] != ST_IDLE);
    bad_busy    = rsp_bgn_vld && rsp_blocked;
    bad_orphan  = rsp_bgn_vld && (cur_state[rsp_bgn_id] != ST_REQ_OPEN) &&
                  (cur_state[rsp_bgn_id] != ST_RSP_WAIT);
    bad_req_end = req_end_vld && (cur_state[req_end_id] != ST_REQ_OPEN);
    bad_rsp_end = rsp_end_vld && (cur_state[rsp_end_id] != ST_RSP_OPEN);
  end

  // state update: every event is judged against the pre-cycle state
  always_comb begin
    nxt_state = cur_state;
    if (req_end_vld && !bad_req_end)
      nxt_state[req_end_id] = ST_RSP_WAIT;
    if (rsp_bgn_vld && !bad_busy && !bad_orphan)
      nxt_state[rsp_bgn_id] = rsp_bgn_upd ? ST_IDLE : ST_RSP_OPEN;
    if (rsp_end_vld && !bad_rsp_end)
      nxt_state[rsp_end_id] = ST_IDLE;
    if (req_bgn_vld && !bad_excl && !bad_reuse) begin
      if (req_bgn_fin)      nxt_state[req_bgn_id] = ST_IDLE;
      else if (req_bgn_upd) nxt_state[req_bgn_id] = ST_RSP_WAIT;
      else                  nxt_state[req_bgn_id] = ST_REQ_OPEN;
    end
  end

  // lowest code wins
  always_comb begin
    if (bad_excl)         err_c = ERR_EXCL;
    else if (bad_reuse)   err_c = ERR_REUSE;
    else if (bad_busy)    err_c = ERR_RSP_BUSY;
    else if (bad_orphan)  err_c = ERR_ORPHAN;
    else if (bad_req_end) err_c = ERR_REQ_END;
    else if (bad_rsp_end) err_c = ERR_RSP_END;
    else                  err_c = ERR_NONE;
  end
endmodule

// File: rtl/split_phase_monitor.sv
module split_phase_monitor
  import sph_pkg::*;
#(
  parameter int ID_W = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            req_bgn_vld,
  input  logic [ID_W-1:0] req_bgn_id,
  input  logic            req_bgn_upd,
  input  logic            req_bgn_fin,
  input  logic            req_end_vld,
  input  logic [ID_W-1:0] req_end_id,
  input  logic            rsp_bgn_vld,
  input  logic [ID_W-1:0] rsp_bgn_id,
  input  logic            rsp_bgn_upd,
  input  logic            rsp_end_vld,
  input  logic [ID_W-1:0] rsp_end_id,
  output logic            err_vld,
  output logic [2:0]      err_code
);
  localparam int NUM_IDS = 1 << ID_W;

  sph_state_e [NUM_IDS-1:0] cur_state, nxt_state;
  logic [NUM_IDS-1:0]       req_open_vec, rsp_open_vec;
  logic [2:0]               err_c;

  sph_state_table #(.ID_W(ID_W)) u_table (
    .clk          (clk),
    .rst          (rst),
    .nxt_state    (nxt_state),
    .cur_state    (cur_state),
    .req_open_vec (req_open_vec),
    .rsp_open_vec (rsp_open_vec)
  );

  sph_rules #(.ID_W(ID_W)) u_rules (
    .cur_state   (cur_state),
    .req_bgn_vld (req_bgn_vld),
    .req_bgn_id  (req_bgn_id),
    .req_bgn_upd (req_bgn_upd),
    .req_bgn_fin (req_bgn_fin),
    .req_end_vld (req_end_vld),
    .req_end_id  (req_end_id),
    .rsp_bgn_vld (rsp_bgn_vld),
    .rsp_bgn_id  (rsp_bgn_id),
    .rsp_bgn_upd (rsp_bgn_upd),
    .rsp_end_vld (rsp_end_vld),
    .rsp_end_id  (rsp_end_id),
    .nxt_state   (nxt_state),
    .err_c       (err_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      err_vld  <= 1'b0;
      err_code <= ERR_NONE;
    end else begin
      err_vld  <= (err_c != ERR_NONE);
      err_code <= err_c;
    end
  end

  // R2: request-begin inside the exclusion window is flagged with code 1
  a_r2_excl_flagged: assert property (@(posedge clk) disable iff (rst)
    (req_bgn_vld && (|req_open_vec)) |=> (err_vld && err_code == ERR_EXCL));

  // R9: request-end for an ID not waiting for one raises the pulse
  a_r9_stray_req_end: assert property (@(posedge clk) disable iff (rst)
    (req_end_vld && !req_open_vec[req_end_id]) |=> err_vld);

  // R6: an accepted early-completed request leaves its ID idle
  a_r6_early_idle: assert property (@(posedge clk) disable iff (rst)
    (req_bgn_vld && req_bgn_fin && !(|req_open_vec) &&
     cur_state[req_bgn_id] == ST_IDLE) |=> (cur_state[$past(req_bgn_id)] == ST_IDLE));

  // R10: the pulse always carries a nonzero code
  a_r10_code_with_pulse: assert property (@(posedge clk) disable iff (rst)
    err_vld |-> (err_code != ERR_NONE));
endmodule

// File: tb/split_phase_monitor_tb.sv
module split_phase_monitor_tb;
  localparam int ID_W = 3;

  logic clk = 1'b0;
  logic rst;
  logic req_bgn_vld, req_bgn_upd, req_bgn_fin, req_end_vld;
  logic rsp_bgn_vld, rsp_bgn_upd, rsp_end_vld;
  logic [ID_W-1:0] req_bgn_id, req_end_id, rsp_bgn_id, rsp_end_id;
  logic err_vld;
  logic [2:0] err_code;
  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  split_phase_monitor #(.ID_W(ID_W)) u_dut (
    .clk(clk), .rst(rst),
    .req_bgn_vld(req_bgn_vld), .req_bgn_id(req_bgn_id),
    .req_bgn_upd(req_bgn_upd), .req_bgn_fin(req_bgn_fin),
    .req_end_vld(req_end_vld), .req_end_id(req_end_id),
    .rsp_bgn_vld(rsp_bgn_vld), .rsp_bgn_id(rsp_bgn_id),
    .rsp_bgn_upd(rsp_bgn_upd),
    .rsp_end_vld(rsp_end_vld), .rsp_end_id(rsp_end_id),
    .err_vld(err_vld), .err_code(err_code)
  );

  task automatic clear_in();
    req_bgn_vld = 0; req_bgn_upd = 0; req_bgn_fin = 0; req_bgn_id = '0;
    req_end_vld = 0; req_end_id = '0;
    rsp_bgn_vld = 0; rsp_bgn_upd = 0; rsp_bgn_id = '0;
    rsp_end_vld = 0; rsp_end_id = '0;
  endtask

  task automatic rb(input int id, input bit upd = 0, input bit fin = 0);
    req_bgn_vld = 1; req_bgn_id = id[ID_W-1:0]; req_bgn_upd = upd; req_bgn_fin = fin;
  endtask
  task automatic re(input int id);
    req_end_vld = 1; req_end_id = id[ID_W-1:0];
  endtask
  task automatic sb(input int id, input bit upd = 0);
    rsp_bgn_vld = 1; rsp_bgn_id = id[ID_W-1:0]; rsp_bgn_upd = upd;
  endtask
  task automatic se(input int id);
    rsp_end_vld = 1; rsp_end_id = id[ID_W-1:0];
  endtask

  // apply staged events for one edge, then check the registered error output
  task automatic step(input string req, input bit ev, input logic [2:0] ec);
    @(posedge clk); #2;
    clear_in();
    total++;
    if (err_vld !== ev || err_code !== ec) begin
      bad++;
      $display("FAIL %s: err_vld=%0b err_code=%0d expected err_vld=%0b err_code=%0d",
               req, err_vld, err_code, ev, ec);
    end
  endtask

  task automatic do_reset();
    clear_in();
    rst = 1;
    @(posedge clk); @(posedge clk); #2;
    rst = 0;
  endtask

  task automatic t_reset();
    do_reset();
    step("R11 idle after reset", 0, 0);
    rb(1); step("R11 setup", 0, 0);
    rst = 1; @(posedge clk); #2; rst = 0;
    rb(2); step("R11 exclusion cleared by reset", 0, 0);
    sb(1); step("R11 ID cleared by reset", 1, 4);
  endtask

  task automatic t_normal();
    do_reset();
    rb(1); step("R1 request-begin", 0, 0);
    se(1); step("R1 response-end too early", 1, 6);
    re(1); step("R1 request-end", 0, 0);
    sb(1); step("R1 response-begin", 0, 0);
    se(1); step("R1 response-end", 0, 0);
    sb(1); step("R1 ID free after response-end", 1, 4);
  endtask

  task automatic t_exclusion();
    do_reset();
    rb(2); step("R2 first request", 0, 0);
    rb(3); step("R2 request during exclusion", 1, 1);
    re(2); rb(3); step("R2 request in same cycle as request-end", 1, 1);
    rb(3); step("R2 request after release", 0, 0);
  endtask

  task automatic t_rsp_backpressure();
    do_reset();
    rb(1); step("R3 setup", 0, 0);
    re(1); step("R3 setup", 0, 0);
    rb(2); step("R3 setup", 0, 0);
    re(2); step("R3 setup", 0, 0);
    sb(1); step("R3 first response", 0, 0);
    sb(2); step("R3 response while end pending", 1, 3);
    se(1); step("R3 end first response", 0, 0);
    sb(2); step("R3 rejected response still owed", 0, 0);
    se(2); step("R3 end second response", 0, 0);
  endtask

  task automatic t_implicit_end();
    do_reset();
    rb(4); step("R4 request", 0, 0);
    sb(4); step("R4 response without request-end", 0, 0);
    rb(5); step("R4 exclusion released", 0, 0);
    re(4); step("R4 late request-end rejected", 1, 5);
    se(4); step("R4 response-end", 0, 0);
  endtask

  task automatic t_updated();
    do_reset();
    rb(6, 1); step("R5 request with updated ack", 0, 0);
    rb(7, 1); step("R5 no exclusion after updated ack", 0, 0);
    sb(6, 1); step("R5 response with updated ack", 0, 0);
    sb(7); step("R5 no response backpressure", 0, 0);
    se(7); step("R5 normal response-end", 0, 0);
    se(6); step("R5 waived response-end not expected", 1, 6);
  endtask

  task automatic t_early();
    do_reset();
    rb(0, 0, 1); step("R6 early completion", 0, 0);
    sb(0); step("R6 response after completion", 1, 4);
    re(0); step("R6 request-end after completion", 1, 5);
    rb(0); step("R6 ID reusable", 0, 0);
  endtask

  task automatic t_out_of_order();
    do_reset();
    rb(1); step("R7 req 1", 0, 0);
    re(1); step("R7 end req 1", 0, 0);
    rb(2); step("R7 req 2", 0, 0);
    re(2); step("R7 end req 2", 0, 0);
    sb(2); step("R7 rsp 2 first", 0, 0);
    se(2); step("R7 end rsp 2", 0, 0);
    sb(1); step("R7 rsp 1 last", 0, 0);
    se(1); step("R7 end rsp 1", 0, 0);
  endtask

  task automatic t_bad_ids();
    do_reset();
    rb(3, 1); step("R8 setup", 0, 0);
    rb(3); step("R8 reuse of live ID", 1, 2);
    sb(6); step("R8 orphan response", 1, 4);
    re(2); step("R9 stray request-end", 1, 5);
    se(2); step("R9 stray response-end", 1, 6);
  endtask

  task automatic t_reporting();
    do_reset();
    rb(1); step("R10 setup", 0, 0);
    rb(1); step("R10 lowest code wins", 1, 1);
    step("R10 pulse lasts one cycle", 0, 0);
    re(5); se(5); step("R10 two errors same cycle", 1, 5);
    re(1); step("R10 checking continues", 0, 0);
  endtask

  initial begin
    clear_in();
    rst = 1;
    t_reset();
    t_normal();
    t_exclusion();
    t_rsp_backpressure();
    t_implicit_end();
    t_updated();
    t_early();
    t_out_of_order();
    t_bad_ids();
    t_reporting();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: run did not end");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule